// File: doc/BRIEF.md
# Sixteen-bit ALU with registered condition codes

This block is the arithmetic and logic stage of a 16-bit datapath. On every cycle it combines two operands under a 4-bit operation code and drives the result straight away, with no register on the way out. An operation can act on the full 16-bit word, or on the low byte only. The supported operations are add, add with carry, subtract, subtract with borrow, compare, AND, OR, XOR and pass-through.

Alongside the result, the block computes six condition codes: carry, parity, auxiliary (nibble) carry, zero, sign and overflow. It holds them in a register that loads on a clock edge only while the flag-write enable is high. The stored carry flag is fed back as the carry-in for the with-carry and with-borrow operations. This lets software chain wide additions and subtractions across several operations. Compare sets the flags exactly as a subtraction would, but it marks its result as not to be written back.

Top module: `alu_core`

## Requirements
- R1: While `rst_n` is low, the flags register is cleared. Once reset is released, `flags` reads 0 until the first enabled write. The bits of `flags` are: bit 0 carry (CF), bit 1 parity (PF), bit 2 auxiliary carry (AF), bit 3 zero (ZF), bit 4 sign (SF), bit 5 overflow (OF).
- R2: Opcode 0 (add) gives a+b, and opcode 1 (add with carry) gives a+b+CF, both modulo the selected size. CF is set on a carry out of the most significant bit of that size.
- R3: Opcode 2 (subtract) gives a-b, and opcode 3 (subtract with borrow) gives a-b-CF, both modulo the selected size. CF is set when a borrow is needed.
- R4: Opcode 4 (compare) sets the flags exactly as opcode 2 would. It drives `result_wr` low and passes `op_a` unchanged to `result`. Every other opcode drives `result_wr` high.
- R5: Opcodes 5, 6, 7 and 8 give a AND b, a OR b, a XOR b and b, in that order. Each of them clears CF, AF and OF.
- R6: When `byte_mode` is 1, only bits 7:0 of the operands are used. The result has bits 15:8 at zero (compare excepted), and carry, sign, zero and overflow refer to the 8-bit value.
- R7: SF equals the most significant bit of the result for the selected size. ZF is set when the result for that size is zero; for compare, this is the difference.
- R8: For arithmetic operations, AF is set on a carry out of bit 3 during addition, or on a borrow into bit 3 during subtraction.
- R9: PF is 1 when bits 7:0 of the result (the difference, for compare) hold an even number of ones, in both sizes.
- R10: OF is set when the signed result of an arithmetic operation does not fit in the selected size.
- R11: `flags` changes only on a rising edge where `flag_we` is 1; otherwise it holds. Add with carry and subtract with borrow take their carry-in from the stored CF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the flags register |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | 16 | First operand (destination value) |
| op_b | input | 16 | Second operand |
| opcode | input | 4 | Operation select, encodings in R2 to R5 |
| byte_mode | input | 1 | 1 selects an 8-bit operation on the low byte |
| flag_we | input | 1 | Loads the computed flags on the next rising edge |
| result | output | 16 | Combinational result |
| result_wr | output | 1 | High when the result is meant to be written back |
| flags | output | 6 | Registered condition codes, layout in R1 |

## Verification
Directed operand pairs sit on each boundary. 0x7FFF+1 and 0x8000-1 separate signed overflow from unsigned carry. FFFF+1 and 0-1 separate carry from borrow, and both also ripple the nibble flag. An 8-bit 0x7F+1, with non-zero upper bytes, shows whether carry, sign and overflow move to bit 7 and whether the upper bits stay clean. Chained add-with-carry and subtract-with-borrow after a carry-setting step, a write with the enable low, and logic operations issued after CF is set separate the flag feedback and hold paths from the plain datapath. A long run of random operands, opcodes, sizes and enables, compared every cycle against a behavioural model working on integers, covers the remaining combinations.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADC  = 4'd1,
    OP_SUB  = 4'd2,
    OP_SBB  = 4'd3,
    OP_CMP  = 4'd4,
    OP_AND  = 4'd5,
    OP_OR   = 4'd6,
    OP_XOR  = 4'd7,
    OP_PASS = 4'd8
  } alu_op_e;

  // bit 0 = carry ... bit 5 = overflow
  typedef struct packed {
    logic of;
    logic sf;
    logic zf;
    logic af;
    logic pf;
    logic cf;
  } alu_flags_t;

  localparam int FLAG_BITS = $bits(alu_flags_t);

  function automatic logic even_ones(input logic [7:0] v);
    return ~^v;
  endfunction

  function automatic logic signed_ovf(input logic sa, input logic sb_eff, input logic sr);
    // same-sign inputs producing an opposite-sign result
    return (sa == sb_eff) && (sr != sa);
  endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  logic         sub,
  input  logic         byte_mode,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         aux,
  output logic         ovf
);
  import alu_pkg::*;

  localparam int H = W / 2;

  logic [W-1:0] b_eff;
  logic         c_eff;
  logic [W:0]   wide;
  logic [H:0]   narrow;
  logic [4:0]   nib;
  logic         raw_carry;

  always_comb begin
    b_eff  = sub ? ~b : b;
    c_eff  = sub ? ~cin : cin;
    wide   = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, c_eff};
    narrow = {1'b0, a[H-1:0]} + {1'b0, b_eff[H-1:0]} + {{H{1'b0}}, c_eff};
    nib    = {1'b0, a[3:0]} + {1'b0, b_eff[3:0]} + {4'b0000, c_eff};
    if (byte_mode) begin
      sum       = {{(W-H){1'b0}}, narrow[H-1:0]};
      raw_carry = narrow[H];
      ovf       = signed_ovf(a[H-1], b_eff[H-1], narrow[H-1]);
    end else begin
      sum       = wide[W-1:0];
      raw_carry = wide[W];
      ovf       = signed_ovf(a[W-1], b_eff[W-1], wide[W-1]);
    end
    // inverted carry of a + ~b + ~cin is the borrow
    cout = raw_carry ^ sub;
    aux  = nib[4] ^ sub;
  end

endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
  parameter int W = 16
) (
  input  alu_pkg::alu_op_e op,
  input  logic [W-1:0]     a,
  input  logic [W-1:0]     b,
  input  logic             byte_mode,
  output logic [W-1:0]     out
);
  import alu_pkg::*;

  localparam int H = W / 2;

  logic [W-1:0] full;
  logic [W-1:0] keep;

  always_comb begin
    unique case (op)
      OP_AND:  full = a & b;
      OP_OR:   full = a | b;
      OP_XOR:  full = a ^ b;
      default: full = b;
    endcase
    keep = byte_mode ? {{(W-H){1'b0}}, {H{1'b1}}} : {W{1'b1}};
    out  = full & keep;
  end

endmodule

// File: rtl/alu_flagreg.sv
module alu_flagreg (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  alu_pkg::alu_flags_t d,
  output alu_pkg::alu_flags_t q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= d;
  end

endmodule

// File: rtl/alu_core.sv
module alu_core #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [3:0]   opcode,
  input  logic         byte_mode,
  input  logic         flag_we,
  output logic [W-1:0] result,
  output logic         result_wr,
  output logic [5:0]   flags
);
  import alu_pkg::*;

  localparam int H = W / 2;

  alu_op_e    op;
  logic       is_arith;
  logic       is_sub;
  logic       uses_cf;
  logic       carry_in;
  logic [W-1:0] arith_val;
  logic [W-1:0] logic_val;
  logic [W-1:0] alu_value;   // value the flags describe
  logic       arith_cout;
  logic       arith_aux;
  logic       arith_ovf;
  alu_flags_t flags_next;
  alu_flags_t flags_q;

  always_comb begin
    op       = alu_op_e'(opcode);
    is_arith = (op == OP_ADD) || (op == OP_ADC) || (op == OP_SUB) ||
               (op == OP_SBB) || (op == OP_CMP);
    is_sub   = (op == OP_SUB) || (op == OP_SBB) || (op == OP_CMP);
    uses_cf  = (op == OP_ADC) || (op == OP_SBB);
    carry_in = uses_cf & flags_q.cf;
  end

  alu_addsub #(.W(W)) u_addsub (
    .a(op_a), .b(op_b), .cin(carry_in), .sub(is_sub), .byte_mode(byte_mode),
    .sum(arith_val), .cout(arith_cout), .aux(arith_aux), .ovf(arith_ovf)
  );

  alu_logic #(.W(W)) u_logic (
    .op(op), .a(op_a), .b(op_b), .byte_mode(byte_mode), .out(logic_val)
  );

  always_comb begin
    alu_value     = is_arith ? arith_val : logic_val;
    flags_next.cf = is_arith & arith_cout;
    flags_next.af = is_arith & arith_aux;
    flags_next.of = is_arith & arith_ovf;
    flags_next.pf = even_ones(alu_value[7:0]);
    flags_next.zf = byte_mode ? (alu_value[H-1:0] == '0) : (alu_value == '0);
    flags_next.sf = byte_mode ? alu_value[H-1] : alu_value[W-1];
  end

  alu_flagreg u_flags (
    .clk(clk), .rst_n(rst_n), .we(flag_we), .d(flags_next), .q(flags_q)
  );

  assign result    = (op == OP_CMP) ? op_a : alu_value;
  assign result_wr = (op != OP_CMP);
  assign flags     = flags_q;

endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] op_a,
  input logic [3:0]   opcode,
  input logic         byte_mode,
  input logic         flag_we,
  input logic [W-1:0] result,
  input logic         result_wr,
  input logic [5:0]   flags
);

  localparam int H = W / 2;

  logic is_cmp;
  logic is_logic_op;
  assign is_cmp      = (opcode == 4'd4);
  assign is_logic_op = (opcode >= 4'd5) && (opcode <= 4'd8);

  a_r11_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_we |=> $stable(flags));

  a_r4_cmp_no_writeback: assert property (@(posedge clk) disable iff (!rst_n)
    is_cmp |-> (!result_wr && result == op_a));

  a_r5_logic_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && is_logic_op) |=> (flags[0] == 1'b0 && flags[2] == 1'b0 && flags[5] == 1'b0));

  a_r6_byte_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_mode && !is_cmp) |-> (result[W-1:H] == '0));

  a_r9_parity: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && !is_cmp) |=> (flags[1] == ~^$past(result[7:0])));

  a_r7_sign: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && !is_cmp) |=> (flags[4] == $past(byte_mode ? result[H-1] : result[W-1])));

endmodule

bind alu_core alu_core_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_a(op_a), .opcode(opcode), .byte_mode(byte_mode),
  .flag_we(flag_we), .result(result), .result_wr(result_wr), .flags(flags)
);

// File: tb/alu_core_bench.sv
module alu_core_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] op_a = '0;
  logic [15:0] op_b = '0;
  logic [3:0]  opcode = '0;
  logic        byte_mode = 1'b0;
  logic        flag_we = 1'b0;
  logic [15:0] result;
  logic        result_wr;
  logic [5:0]  flags;

  int n_run = 0;
  int n_fail = 0;
  logic [5:0] m_flags = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu_core u_alu_core (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .opcode(opcode),
    .byte_mode(byte_mode), .flag_we(flag_we), .result(result),
    .result_wr(result_wr), .flags(flags)
  );

  task automatic check(input string what, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  function automatic int sx(input int v, input int n);
    return (v >= (1 << (n-1))) ? v - (1 << n) : v;
  endfunction

  task automatic step(input logic [15:0] a, input logic [15:0] b, input int op,
                      input bit bm, input bit we, input string tag);
    int n, mask, av, bv, cin, r, s, ss, lo, hi;
    bit ecf, eaf, eof;
    logic [15:0] eres;
    logic [5:0]  ef;
    @(negedge clk);
    op_a = a; op_b = b; opcode = op[3:0]; byte_mode = bm; flag_we = we;
    n    = bm ? 8 : 16;
    mask = (1 << n) - 1;
    hi   = (1 << (n-1)) - 1;
    lo   = -(1 << (n-1));
    av   = int'(a) & mask;
    bv   = int'(b) & mask;
    cin  = (op == 1 || op == 3) ? int'(m_flags[0]) : 0;
    ecf = 0; eaf = 0; eof = 0;
    case (op)
      0, 1: begin
        s = av + bv + cin; r = s & mask; ecf = (s > mask);
        eaf = ((av & 15) + (bv & 15) + cin) > 15;
        ss = sx(av, n) + sx(bv, n) + cin; eof = (ss > hi) || (ss < lo);
      end
      2, 3, 4: begin
        s = av - bv - cin; r = s & mask; ecf = (s < 0);
        eaf = ((av & 15) - (bv & 15) - cin) < 0;
        ss = sx(av, n) - sx(bv, n) - cin; eof = (ss > hi) || (ss < lo);
      end
      5: r = av & bv;
      6: r = av | bv;
      7: r = av ^ bv;
      default: r = bv;
    endcase
    eres = (op == 4) ? a : r[15:0];
    ef = {eof, (((r >> (n-1)) & 1) == 1), (r == 0), eaf,
          (($countones(r & 255) % 2) == 0), ecf};
    #1;
    check({tag, " result"}, result, eres);
    check({tag, " writeback R4"}, {15'd0, result_wr}, {15'd0, (op != 4)});
    @(posedge clk);
    if (we) m_flags = ef;
    #1;
    check({tag, " flags"}, {10'd0, flags}, {10'd0, m_flags});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset flags", {10'd0, flags}, 16'd0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 flags after release", {10'd0, flags}, 16'd0);

    step(16'h7FFF, 16'h0001, 0, 0, 1, "R10 add signed overflow");
    step(16'hFFFF, 16'h0001, 0, 0, 1, "R2 add carry zero R7");
    step(16'h0001, 16'h0001, 1, 0, 1, "R11 adc uses stored CF");
    step(16'h0000, 16'h0001, 2, 0, 1, "R3 sub borrow R8");
    step(16'h0005, 16'h0002, 3, 0, 1, "R11 sbb uses stored CF");
    step(16'h0005, 16'h0005, 4, 0, 1, "R4 compare equal");
    step(16'h0003, 16'h0009, 4, 0, 1, "R4 compare less");
    step(16'h8000, 16'h0001, 2, 0, 1, "R10 sub signed overflow");
    step(16'h0010, 16'h0001, 2, 0, 1, "R8 nibble borrow");
    step(16'h0008, 16'h0008, 0, 0, 1, "R8 nibble carry");
    step(16'h12FF, 16'h3401, 0, 1, 1, "R6 byte add wraps");
    step(16'hAB7F, 16'hCD01, 0, 1, 1, "R6 byte signed overflow R10");
    step(16'h0000, 16'h0001, 2, 0, 1, "R5 setup CF");
    step(16'hF0F0, 16'h0FF0, 5, 0, 1, "R5 and clears");
    step(16'h0000, 16'h0001, 2, 0, 1, "R5 setup CF");
    step(16'hF000, 16'h000F, 6, 0, 1, "R5 or clears");
    step(16'h0003, 16'h0000, 7, 0, 1, "R9 xor even parity");
    step(16'h0001, 16'h0000, 7, 0, 1, "R9 xor odd parity");
    step(16'h1234, 16'h0100, 8, 0, 1, "R9 pass low byte zero");
    step(16'h5678, 16'hFF80, 8, 1, 1, "R6 byte pass sign");
    step(16'hFFFF, 16'h0001, 0, 0, 0, "R11 no write holds");
    step(16'h0001, 16'h0001, 1, 0, 1, "R11 adc after held write");

    for (int i = 0; i < 400; i++) begin
      step(16'($urandom), 16'($urandom), int'($urandom_range(0, 8)),
           1'($urandom), 1'($urandom_range(0, 3) != 0), "R2 R3 R5 random");
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule